// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Queue

This block sits between instruction decode and two execution paths of a pipelined core. Decoded instructions arrive from fetch, up to two per cycle, and wait in a small program-ordered queue. Every cycle the block scans the queue from the oldest entry to the newest and issues the oldest ready memory instruction to the memory path and the oldest ready non-memory instruction to the ALU path. Up to two instructions can leave per cycle, and they may leave out of program order.

Readiness follows a register scoreboard. A busy bit marks every register that is the destination of an issued instruction whose result has not yet been written back. Writeback clears the bit, and the cleared state becomes visible one cycle later. An entry also checks register hazards against every older entry still in the queue. Loads never pass an older store, and stores stay in order among themselves. Issued entries leave in the cycle they issue. The entries that remain close up in order, and the pushes from fetch are appended behind them.

Only register identifiers and an opaque tag are carried. Operand values and execution are handled elsewhere. An instruction word is packed as: tag in bits [27:20], memory flag in bit 19, store flag in bit 18, destination enable in bit 17, destination register in [16:12], first-source enable in bit 11, first source in [10:6], second-source enable in bit 5, second source in [4:0].

Top module: `sb_issue_queue`

## Requirements
- R1: After reset the queue is empty, `free_slots` equals the depth (4), neither issue valid is high, and no register is busy.
- R2: An entry whose enabled source register is busy does not issue. A writeback clear of that register, driven in some cycle, lets the entry issue in the following cycle and not in the same cycle.
- R3: An entry does not issue if an older entry still in the queue writes one of its sources (RAW), writes its destination (WAW), or reads its destination (WAR).
- R4: A ready entry issues even when older entries of the same class are blocked. Among the ready entries of a class, the one nearest entry 0 is chosen.
- R5: At most one memory instruction (bit 19 = 1) appears on the memory issue port and at most one non-memory instruction (bit 19 = 0) on the ALU issue port per cycle. Both can issue in the same cycle.
- R6: No instruction of a class issues while that class's free-slot input is 0. Issue resumes in the cycle the input becomes non-zero.
- R7: A load (bit 19 = 1, bit 18 = 0) does not issue while an older store (bits 19 and 18 = 1) is in the queue. A store does not issue while an older store is in the queue.
- R8: Issued entries are removed at the clock edge that ends their issue cycle. The entries that remain keep their relative order, and same-cycle pushes go in behind them, push 0 ahead of push 1. `free_slots` reports depth minus occupancy.
- R9: An entry whose enabled destination register is busy does not issue until a writeback clears that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 2 | Bit 0 pushes `push_insn0`, bit 1 pushes `push_insn1` |
| push_insn0 | input | 28 | First pushed instruction (older) |
| push_insn1 | input | 28 | Second pushed instruction |
| mem_free | input | 2 | Free slots in the memory-path queue, as of the previous edge |
| alu_free | input | 2 | Free slots in the ALU-path queue, as of the previous edge |
| wb_valid | input | 2 | Writeback clear enables |
| wb_reg0 | input | 5 | Register cleared by writeback 0 |
| wb_reg1 | input | 5 | Register cleared by writeback 1 |
| mem_issue_valid | output | 1 | A memory instruction issues this cycle |
| mem_issue_insn | output | 28 | Issued memory instruction |
| alu_issue_valid | output | 1 | A non-memory instruction issues this cycle |
| alu_issue_insn | output | 28 | Issued non-memory instruction |
| free_slots | output | 3 | Empty queue entries |

## Verification
Issue removal and fetch append can fall in the same cycle. When they do, the surviving entries must close up before the new words land, or a pushed word overwrites a survivor or lands out of order. The bench provokes this by holding a blocked ALU entry behind a ready load, then pushing two new instructions in the cycle the load issues. It judges the result in the next cycle from the chosen issues and the free count: the new ALU entry must be picked ahead of the still-blocked older one, and the new load must issue alongside it. A second overlap, a writeback clear in the same cycle as a waiting consumer, is checked by confirming the consumer stays put that cycle and issues in the next.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
   localparam int TAG_W = 8;
   localparam int RID_W = 5;

   typedef struct packed {
      logic [TAG_W-1:0] tag;
      logic             is_mem;
      logic             is_store;
      logic             dst_en;
      logic [RID_W-1:0] dst;
      logic             s1_en;
      logic [RID_W-1:0] s1;
      logic             s2_en;
      logic [RID_W-1:0] s2;
   } sbq_insn_t;

   localparam int INSN_W = $bits(sbq_insn_t);

   function automatic logic sbq_reads(sbq_insn_t x, logic [RID_W-1:0] r);
      return (x.s1_en && (x.s1 == r)) || (x.s2_en && (x.s2 == r));
   endfunction
endpackage

// File: rtl/sbq_scoreboard.sv
module sbq_scoreboard
   import sbq_pkg::*;
#(
   parameter int NREG = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       set_en,
   input  logic [RID_W-1:0] set_reg0,
   input  logic [RID_W-1:0] set_reg1,
   input  logic [1:0]       clr_en,
   input  logic [RID_W-1:0] clr_reg0,
   input  logic [RID_W-1:0] clr_reg1,
   output logic [NREG-1:0]  busy
);
   logic [NREG-1:0] busy_r, busy_nxt;

   always_comb begin
      busy_nxt = busy_r;
      if (clr_en[0]) busy_nxt[clr_reg0] = 1'b0;
      if (clr_en[1]) busy_nxt[clr_reg1] = 1'b0;
      if (set_en[0]) busy_nxt[set_reg0] = 1'b1;
      if (set_en[1]) busy_nxt[set_reg1] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) busy_r <= '0;
      else        busy_r <= busy_nxt;
   end

   assign busy = busy_r;

   // R2: a writeback clear not overridden by a set leaves the register free next cycle
   assert_clear_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en[0] && !(set_en[0] && set_reg0 == clr_reg0) && !(set_en[1] && set_reg1 == clr_reg0))
      |=> !busy[$past(clr_reg0)]);

   // R9: an issued destination is marked busy next cycle
   assert_set_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_en[0] |=> busy[$past(set_reg0)]);
endmodule

// File: rtl/sbq_hazard.sv
module sbq_hazard
   import sbq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int IDX   = 0,
   parameter int NREG  = 32
) (
   input  sbq_insn_t [DEPTH-1:0] ents,
   input  logic [DEPTH-1:0]      vld,
   input  logic [NREG-1:0]       busy,
   output logic                  ready
);
   sbq_insn_t me;
   logic      blk;

   always_comb begin
      me  = ents[IDX];
      blk = 1'b0;
      if (me.s1_en && busy[me.s1])   blk = 1'b1;
      if (me.s2_en && busy[me.s2])   blk = 1'b1;
      if (me.dst_en && busy[me.dst]) blk = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
         if (j < IDX && vld[j]) begin
            if (ents[j].dst_en && sbq_reads(me, ents[j].dst))              blk = 1'b1;
            if (ents[j].dst_en && me.dst_en && ents[j].dst == me.dst)     blk = 1'b1;
            if (me.dst_en && sbq_reads(ents[j], me.dst))                   blk = 1'b1;
            if (me.is_mem && ents[j].is_mem && ents[j].is_store)          blk = 1'b1;
         end
      end
      ready = vld[IDX] && !blk;
   end
endmodule

// File: rtl/sbq_pick.sv
module sbq_pick #(
   parameter int N    = 4,
   localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      found = |req;
   end
endmodule

// File: rtl/sb_issue_queue.sv
module sb_issue_queue
   import sbq_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int MEM_SLOTS = 2,
   parameter int ALU_SLOTS = 2,
   localparam int NREG  = 1 << RID_W,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH),
   localparam int MF_W  = $clog2(MEM_SLOTS + 1),
   localparam int AF_W  = $clog2(ALU_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        push_valid,
   input  logic [INSN_W-1:0] push_insn0,
   input  logic [INSN_W-1:0] push_insn1,
   input  logic [MF_W-1:0]   mem_free,
   input  logic [AF_W-1:0]   alu_free,
   input  logic [1:0]        wb_valid,
   input  logic [RID_W-1:0]  wb_reg0,
   input  logic [RID_W-1:0]  wb_reg1,
   output logic              mem_issue_valid,
   output logic [INSN_W-1:0] mem_issue_insn,
   output logic              alu_issue_valid,
   output logic [INSN_W-1:0] alu_issue_insn,
   output logic [CNT_W-1:0]  free_slots
);
   generate
      if (DEPTH < 2 || DEPTH > 16) begin : g_bad_depth
         $error("sb_issue_queue: DEPTH must be within 2..16");
      end
      if (MEM_SLOTS < 1 || ALU_SLOTS < 1) begin : g_bad_slots
         $error("sb_issue_queue: downstream slot counts must be at least 1");
      end
   endgenerate

   sbq_insn_t [DEPTH-1:0] q_r, q_nxt;
   logic [CNT_W-1:0]      cnt_r, cnt_nxt;
   logic [DEPTH-1:0]      vld, rdy, mem_req, alu_req, take;
   logic [NREG-1:0]       busy;
   logic                  mem_found, alu_found;
   logic [IDX_W-1:0]      mem_idx, alu_idx;
   sbq_insn_t             mem_sel, alu_sel;

   // per-entry readiness
   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
         assign vld[gi] = (CNT_W'(gi) < cnt_r);
         sbq_hazard #(.DEPTH(DEPTH), .IDX(gi), .NREG(NREG)) i_haz (
            .ents  (q_r),
            .vld   (vld),
            .busy  (busy),
            .ready (rdy[gi])
         );
         assign mem_req[gi] = rdy[gi] &&  q_r[gi].is_mem && (mem_free != '0);
         assign alu_req[gi] = rdy[gi] && !q_r[gi].is_mem && (alu_free != '0);
      end
   endgenerate

   sbq_pick #(.N(DEPTH)) i_pick_mem (.req(mem_req), .found(mem_found), .idx(mem_idx));
   sbq_pick #(.N(DEPTH)) i_pick_alu (.req(alu_req), .found(alu_found), .idx(alu_idx));

   assign mem_sel         = q_r[mem_idx];
   assign alu_sel         = q_r[alu_idx];
   assign mem_issue_valid = mem_found;
   assign alu_issue_valid = alu_found;
   assign mem_issue_insn  = mem_sel;
   assign alu_issue_insn  = alu_sel;
   assign free_slots      = CNT_W'(DEPTH) - cnt_r;

   // close up survivors, then append pushes
   always_comb begin
      int k;
      q_nxt = '0;
      k     = 0;
      for (int i = 0; i < DEPTH; i++) begin
         take[i] = (mem_found && mem_idx == IDX_W'(i)) || (alu_found && alu_idx == IDX_W'(i));
         if (vld[i] && !take[i]) begin
            q_nxt[k] = q_r[i];
            k++;
         end
      end
      if (push_valid[0] && k < DEPTH) begin
         q_nxt[k] = sbq_insn_t'(push_insn0);
         k++;
      end
      if (push_valid[1] && k < DEPTH) begin
         q_nxt[k] = sbq_insn_t'(push_insn1);
         k++;
      end
      cnt_nxt = CNT_W'(k);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r   <= '0;
         cnt_r <= '0;
      end else begin
         q_r   <= q_nxt;
         cnt_r <= cnt_nxt;
      end
   end

   sbq_scoreboard #(.NREG(NREG)) i_sb (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   ({alu_found && alu_sel.dst_en, mem_found && mem_sel.dst_en}),
      .set_reg0 (mem_sel.dst),
      .set_reg1 (alu_sel.dst),
      .clr_en   (wb_valid),
      .clr_reg0 (wb_reg0),
      .clr_reg1 (wb_reg1),
      .busy     (busy)
   );

   // R5: each port carries only its own class
   assert_port_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_issue_valid |-> mem_sel.is_mem) and (alu_issue_valid |-> !alu_sel.is_mem));

   // R6: no issue into a full downstream queue
   assert_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_issue_valid |-> mem_free != '0) and (alu_issue_valid |-> alu_free != '0));

   // R2: an issued source was not busy
   assert_src_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_issue_valid && alu_sel.s1_en) |-> !busy[alu_sel.s1]);

   // R3: a same-cycle pair never shares a destination
   assert_pair_waw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_issue_valid && alu_issue_valid && mem_sel.dst_en && alu_sel.dst_en)
      |-> mem_sel.dst != alu_sel.dst);

   // R8: fetch never pushes beyond the room reported
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(push_valid) <= int'(free_slots));
endmodule

// File: tb/test_sb_issue_queue.sv
`timescale 1ns/1ps
module test_sb_issue_queue;
   import sbq_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        push_valid;
   logic [INSN_W-1:0] push_insn0, push_insn1;
   logic [1:0]        mem_free, alu_free;
   logic [1:0]        wb_valid;
   logic [RID_W-1:0]  wb_reg0, wb_reg1;
   logic              mem_issue_valid, alu_issue_valid;
   logic [INSN_W-1:0] mem_issue_insn, alu_issue_insn;
   logic [2:0]        free_slots;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   sb_issue_queue i_sb_issue_queue (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_insn0(push_insn0), .push_insn1(push_insn1),
      .mem_free(mem_free), .alu_free(alu_free),
      .wb_valid(wb_valid), .wb_reg0(wb_reg0), .wb_reg1(wb_reg1),
      .mem_issue_valid(mem_issue_valid), .mem_issue_insn(mem_issue_insn),
      .alu_issue_valid(alu_issue_valid), .alu_issue_insn(alu_issue_insn),
      .free_slots(free_slots)
   );

   function automatic logic [INSN_W-1:0] mk(int tag, bit m, bit st, bit de, int d,
                                             bit e1, int a, bit e2, int b);
      sbq_insn_t x;
      x.tag = TAG_W'(tag); x.is_mem = m; x.is_store = st;
      x.dst_en = de; x.dst = RID_W'(d);
      x.s1_en = e1; x.s1 = RID_W'(a);
      x.s2_en = e2; x.s2 = RID_W'(b);
      return x;
   endfunction

   task automatic chk(string req, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // expected issue state; a tag of -1 means no issue on that port
   task automatic expect_issue(string req, int mtag, int atag);
      sbq_insn_t m, a;
      m = mem_issue_insn; a = alu_issue_insn;
      chk({req, " mem tag"}, mem_issue_valid ? int'(m.tag) : -1, mtag);
      chk({req, " alu tag"}, alu_issue_valid ? int'(a.tag) : -1, atag);
   endtask

   task automatic next_cycle();
      @(posedge clk); #1;
      push_valid = 2'b00;
      wb_valid   = 2'b00;
   endtask

   task automatic push2(logic [INSN_W-1:0] a, logic [INSN_W-1:0] b);
      push_insn0 = a; push_insn1 = b; push_valid = 2'b11;
   endtask

   task automatic push1(logic [INSN_W-1:0] a);
      push_insn0 = a; push_valid = 2'b01;
   endtask

   task automatic wb2(int a, int b);
      wb_reg0 = RID_W'(a); wb_reg1 = RID_W'(b); wb_valid = 2'b11;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 free", int'(free_slots), 4);
      expect_issue("R1", -1, -1);
   endtask

   task automatic t_dual();
      push2(mk(1, 0, 0, 1, 1, 1, 2, 1, 3), mk(2, 1, 0, 1, 4, 1, 5, 0, 0));
      next_cycle(); #1;
      chk("R8 free after two pushes", int'(free_slots), 2);
      expect_issue("R5 dual issue", 2, 1);
      next_cycle(); #1;
      chk("R8 free after removal", int'(free_slots), 4);
      expect_issue("R8 empty", -1, -1);
   endtask

   task automatic t_inflight_raw();
      push1(mk(3, 0, 0, 1, 6, 1, 1, 0, 0));
      next_cycle(); #1;
      expect_issue("R2 busy source", -1, -1);
      wb_reg0 = 5'd1; wb_valid = 2'b01; #1;
      expect_issue("R2 clear same cycle", -1, -1);
      next_cycle(); #1;
      expect_issue("R2 clear next cycle", -1, 3);
      next_cycle();
   endtask

   task automatic t_inflight_waw();
      push1(mk(4, 0, 0, 1, 6, 1, 9, 0, 0));
      next_cycle(); #1;
      expect_issue("R9 busy destination", -1, -1);
      wb2(6, 4);
      next_cycle(); #1;
      expect_issue("R9 after clear", -1, 4);
      next_cycle();
      wb_reg0 = 5'd6; wb_valid = 2'b01;
      next_cycle();
   endtask

   task automatic t_queue_hazards();
      push1(mk(9, 0, 0, 1, 10, 0, 0, 0, 0));
      next_cycle(); next_cycle();
      alu_free = 2'd0;
      push2(mk(10, 0, 0, 1, 11, 1, 10, 0, 0), mk(11, 0, 0, 1, 12, 1, 11, 0, 0));
      next_cycle();
      push2(mk(12, 0, 0, 1, 14, 1, 2, 0, 0), mk(13, 0, 0, 1, 11, 1, 3, 0, 0));
      next_cycle(); #1;
      chk("R8 full", int'(free_slots), 0);
      alu_free = 2'd2; #1;
      expect_issue("R4 younger passes blocked", -1, 12);
      next_cycle(); #1;
      chk("R8 free after middle removal", int'(free_slots), 1);
      expect_issue("R3 RAW/WAW vs older", -1, -1);
      push1(mk(14, 0, 0, 1, 3, 1, 4, 0, 0));
      next_cycle(); #1;
      chk("R8 refill", int'(free_slots), 0);
      expect_issue("R3 WAR vs older", -1, -1);
      wb_reg0 = 5'd10; wb_valid = 2'b01;
      next_cycle(); #1;
      expect_issue("R3 oldest released", -1, 10);
      next_cycle(); #1;
      expect_issue("R3 RAW on in-flight", -1, -1);
      wb_reg0 = 5'd11; wb_valid = 2'b01;
      next_cycle(); #1;
      expect_issue("R3 WAR holds later writer", -1, 11);
      next_cycle(); #1;
      expect_issue("R8 order kept", -1, 13);
      next_cycle(); #1;
      expect_issue("R3 WAR lifted", -1, 14);
      next_cycle(); #1;
      chk("R8 drained", int'(free_slots), 4);
      wb2(14, 11);
      next_cycle();
      wb2(12, 3);
      next_cycle();
   endtask

   task automatic t_structural();
      mem_free = 2'd0; alu_free = 2'd0;
      push2(mk(20, 1, 0, 1, 20, 1, 21, 0, 0), mk(21, 0, 0, 1, 15, 1, 16, 0, 0));
      next_cycle(); #1;
      expect_issue("R6 both full", -1, -1);
      mem_free = 2'd1; #1;
      expect_issue("R6 memory room", 20, -1);
      next_cycle(); #1;
      chk("R8 free", int'(free_slots), 3);
      alu_free = 2'd1; #1;
      expect_issue("R6 alu room", -1, 21);
      next_cycle();
      mem_free = 2'd2; alu_free = 2'd2;
      wb2(20, 15);
      next_cycle();
   endtask

   task automatic t_mem_order();
      push1(mk(29, 0, 0, 1, 22, 0, 0, 0, 0));
      next_cycle(); next_cycle();
      mem_free = 2'd0;
      push2(mk(30, 1, 1, 0, 0, 1, 22, 1, 26), mk(31, 1, 0, 1, 23, 1, 24, 0, 0));
      next_cycle();
      push2(mk(32, 1, 1, 0, 0, 1, 25, 1, 26), mk(33, 0, 0, 1, 27, 1, 28, 0, 0));
      next_cycle();
      mem_free = 2'd2; #1;
      expect_issue("R7 store blocked, alu free", -1, 33);
      next_cycle(); #1;
      expect_issue("R7 load behind store", -1, -1);
      wb_reg0 = 5'd22; wb_valid = 2'b01;
      next_cycle(); #1;
      expect_issue("R7 first store", 30, -1);
      next_cycle(); #1;
      expect_issue("R7 load before later store", 31, -1);
      next_cycle(); #1;
      expect_issue("R7 later store", 32, -1);
      next_cycle();
      wb2(23, 27);
      next_cycle();
   endtask

   task automatic t_push_issue_same();
      push1(mk(39, 0, 0, 1, 5, 0, 0, 0, 0));
      next_cycle(); next_cycle();
      mem_free = 2'd0;
      push2(mk(40, 0, 0, 1, 8, 1, 5, 0, 0), mk(41, 1, 0, 1, 9, 1, 10, 0, 0));
      next_cycle();
      mem_free = 2'd2; #1;
      expect_issue("R8 load issues", 41, -1);
      push2(mk(42, 0, 0, 1, 17, 1, 18, 0, 0), mk(43, 1, 0, 1, 19, 1, 18, 0, 0));
      next_cycle(); #1;
      chk("R8 free after append", int'(free_slots), 1);
      expect_issue("R8 append behind survivor", 43, 42);
      next_cycle(); #1;
      chk("R8 survivor left", int'(free_slots), 3);
      expect_issue("R9 survivor still blocked", -1, -1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; push_valid = 2'b00; push_insn0 = '0; push_insn1 = '0;
      mem_free = 2'd2; alu_free = 2'd2; wb_valid = 2'b00; wb_reg0 = '0; wb_reg1 = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_dual();
      t_inflight_raw();
      t_inflight_waw();
      t_queue_hazards();
      t_structural();
      t_mem_order();
      t_push_issue_same();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule